// File: doc/BRIEF.md
# Program/Erase Suspend-Resume Command Handler

This block sits in the command path of a non-volatile memory controller. It takes single-cycle command writes, starts a word program, a block erase or a buffered factory program, and lets software pause a running program or erase and later continue it. The algorithm itself is stood in for by a countdown engine. A pause request does not take effect at once. The engine first runs a fixed settling interval to reach a safe point, then parks with its remaining count frozen.

While the engine is parked, the handler reports which kind of operation is paused through the status byte. Only a short list of commands gets through, and all other writes are dropped. If an array read targets the paused word (program) or the paused block (erase), the handler raises a flag marking the returned data as not valid. A resume command continues the parked work from the count where it stopped, so the total run time of an operation does not depend on how often it was paused.

Top module: `srh_top`

## Requirements
- R1: In idle, a write of 0x41 starts a word program at `wr_addr`, 0x22 starts an erase of the block holding `wr_addr`, and 0x83 starts a buffered factory program. From the cycle after the start, status bit 7 reads 0 and `rd_sel` reads 1 (status). The operation occupies PROG_CYC, ERASE_CYC or FACT_CYC running cycles, after which bit 7 returns to 1.
- R2: A single write of 0xB5 at any address while a program or erase runs is a pause request. The engine spends SETTLE_CYC cycles with bit 7 still 0. After that, bit 7 reads 1, together with bit 2 for a paused program or bit 6 for a paused erase.
- R3: The status byte uses bit 7 for ready, bit 6 for a paused erase and bit 2 for a paused program. Every other bit is 0. Bits 6 and 2 are never set together, and either one implies bit 7. After reset the status is 0x80.
- R4: A write of 0xD5 while paused clears bits 6 and 2 and drops bit 7 to 0 in the next cycle. The remaining work then continues, so an operation still ends after exactly its full count of running cycles.
- R5: While paused, only 0xD5, 0xFF, 0x70 and 0x90 take effect. Any other write, including new start and pause commands, leaves the status and `rd_sel` unchanged.
- R6: `rd_invalid` is 1 only while paused with `rd_sel` = 0 (array). For a paused program it requires `rd_addr` to equal the programmed word. For a paused erase it requires `rd_addr` to lie in the same block, where the block is given by the address bits from BLK_LSB upward.
- R7: A 0xB5 write while idle has no effect on status or `rd_sel`.
- R8: A 0xB5 write during a buffered factory program is ignored. The operation keeps running and ends on time.
- R9: 0xFF, 0x70 and 0x90 set `rd_sel` to 0 (array), 1 (status) and 2 (signature) in any engine state.
- R10: While an operation runs or settles, writes other than read selects and a pause request accepted in the running phase are ignored. A second 0xB5 or a 0xD5 written during settling has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Command write strobe, one cycle per command |
| wr_addr | input | AW | Address of the command write |
| wr_data | input | 8 | Command code |
| rd_addr | input | AW | Address of the current array read |
| status | output | 8 | Status byte (bits 7, 6, 2 used) |
| rd_sel | output | 2 | Read source: 0 array, 1 status, 2 signature |
| rd_invalid | output | 1 | Current array read hits the paused region |

## Verification
The hardest state to reach is a paused operation with a specific kind of read or command arriving inside the narrow window around it. Examples are a pause that lands during settling, a resume written before the engine has parked, and an array read one word away from the paused target. Directed sequences put the engine into each of these windows at known cycle offsets. Random command traffic, with read addresses steered toward the latched target, then covers the remaining interleavings. A cycle-level reference model in the bench predicts the status, `rd_sel` and `rd_invalid` after every edge.

// File: rtl/srh_pkg.sv
package srh_pkg;

    localparam logic [7:0] CODE_PROG    = 8'h41;
    localparam logic [7:0] CODE_ERASE   = 8'h22;
    localparam logic [7:0] CODE_FACT    = 8'h83;
    localparam logic [7:0] CODE_SUSP    = 8'hB5;
    localparam logic [7:0] CODE_RESUME  = 8'hD5;
    localparam logic [7:0] CODE_RD_ARR  = 8'hFF;
    localparam logic [7:0] CODE_RD_STAT = 8'h70;
    localparam logic [7:0] CODE_RD_SIG  = 8'h90;

    typedef enum logic [3:0] {
        C_NONE, C_PROG, C_ERASE, C_FACT, C_SUSP,
        C_RESUME, C_RD_ARR, C_RD_STAT, C_RD_SIG
    } cmd_e;

    typedef enum logic [1:0] {RS_ARRAY = 2'd0, RS_STATUS = 2'd1, RS_SIG = 2'd2} rsel_e;
    typedef enum logic [1:0] {OP_PROG, OP_ERASE, OP_FACT} op_e;
    typedef enum logic [1:0] {EN_IDLE, EN_RUN, EN_SETTLE, EN_PAUSED} eng_e;

    function automatic cmd_e decode_cmd(input logic [7:0] b);
        case (b)
            CODE_PROG:    return C_PROG;
            CODE_ERASE:   return C_ERASE;
            CODE_FACT:    return C_FACT;
            CODE_SUSP:    return C_SUSP;
            CODE_RESUME:  return C_RESUME;
            CODE_RD_ARR:  return C_RD_ARR;
            CODE_RD_STAT: return C_RD_STAT;
            CODE_RD_SIG:  return C_RD_SIG;
            default:      return C_NONE;
        endcase
    endfunction

    function automatic logic is_read_sel(input cmd_e c);
        return (c == C_RD_ARR) || (c == C_RD_STAT) || (c == C_RD_SIG);
    endfunction

    function automatic logic is_start(input cmd_e c);
        return (c == C_PROG) || (c == C_ERASE) || (c == C_FACT);
    endfunction

endpackage

// File: rtl/srh_engine.sv
module srh_engine
    import srh_pkg::*;
#(
    parameter int PROG_CYC   = 6,
    parameter int ERASE_CYC  = 24,
    parameter int FACT_CYC   = 12,
    parameter int SETTLE_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  op_e  start_op,
    input  logic pause_req,
    input  logic resume_req,
    output eng_e state,
    output op_e  cur_op
);
    localparam int MAX_A = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int MAXC  = (MAX_A > FACT_CYC) ? MAX_A : FACT_CYC;
    localparam int CW    = $clog2(MAXC + 1);
    localparam int SW    = $clog2(SETTLE_CYC + 1);

    logic [CW-1:0] cnt;
    logic [SW-1:0] settle;

    function automatic logic [CW-1:0] load_of(input op_e o);
        case (o)
            OP_ERASE: return CW'(ERASE_CYC);
            OP_FACT:  return CW'(FACT_CYC);
            default:  return CW'(PROG_CYC);
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= EN_IDLE;
            cur_op <= OP_PROG;
            cnt    <= '0;
            settle <= '0;
        end else begin
            case (state)
                EN_IDLE: begin
                    if (start) begin
                        state  <= EN_RUN;
                        cur_op <= start_op;
                        cnt    <= load_of(start_op);
                    end
                end
                EN_RUN: begin
                    if (cnt == CW'(1)) begin
                        state <= EN_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt - CW'(1);
                        if (pause_req) begin
                            state  <= EN_SETTLE;
                            settle <= SW'(SETTLE_CYC);
                        end
                    end
                end
                EN_SETTLE: begin
                    settle <= settle - SW'(1);
                    if (settle == SW'(1)) state <= EN_PAUSED;
                end
                EN_PAUSED: begin
                    if (resume_req) state <= EN_RUN;
                end
                default: state <= EN_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/srh_arbiter.sv
module srh_arbiter
    import srh_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  cmd_e  cmd,
    input  eng_e  eng,
    input  op_e   cur_op,
    output logic  start,
    output op_e   start_op,
    output logic  pause_req,
    output logic  resume_req,
    output rsel_e rsel
);
    always_comb begin
        case (cmd)
            C_ERASE: start_op = OP_ERASE;
            C_FACT:  start_op = OP_FACT;
            default: start_op = OP_PROG;
        endcase
        start      = wr_en && (eng == EN_IDLE) && is_start(cmd);
        pause_req  = wr_en && (eng == EN_RUN) && (cmd == C_SUSP) && (cur_op != OP_FACT);
        resume_req = wr_en && (eng == EN_PAUSED) && (cmd == C_RESUME);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsel <= RS_ARRAY;
        end else if (wr_en && is_read_sel(cmd)) begin
            case (cmd)
                C_RD_STAT: rsel <= RS_STATUS;
                C_RD_SIG:  rsel <= RS_SIG;
                default:   rsel <= RS_ARRAY;
            endcase
        end else if (start) begin
            rsel <= RS_STATUS;
        end
    end
endmodule

// File: rtl/srh_status.sv
module srh_status
    import srh_pkg::*;
#(
    parameter int AW      = 12,
    parameter int BLK_LSB = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] wr_addr,
    input  eng_e          eng,
    input  op_e           cur_op,
    input  rsel_e         rsel,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    status,
    output logic          rd_invalid
);
    logic [AW-1:0] tgt;
    logic          paused, hit;

    always_ff @(posedge clk) begin
        if (rst)        tgt <= '0;
        else if (start) tgt <= wr_addr;
    end

    always_comb begin
        paused = (eng == EN_PAUSED);
        status = '0;
        status[7] = (eng == EN_IDLE) || paused;
        status[6] = paused && (cur_op == OP_ERASE);
        status[2] = paused && (cur_op == OP_PROG);
        if (cur_op == OP_ERASE) hit = (rd_addr[AW-1:BLK_LSB] == tgt[AW-1:BLK_LSB]);
        else                    hit = (rd_addr == tgt);
        rd_invalid = paused && (rsel == RS_ARRAY) && hit;
    end
endmodule

// File: rtl/srh_top.sv
module srh_top
    import srh_pkg::*;
#(
    parameter int AW         = 12,
    parameter int BLK_LSB    = 6,
    parameter int PROG_CYC   = 6,
    parameter int ERASE_CYC  = 24,
    parameter int FACT_CYC   = 12,
    parameter int SETTLE_CYC = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    status,
    output logic [1:0]    rd_sel,
    output logic          rd_invalid
);
    cmd_e  cmd;
    eng_e  eng;
    op_e   cur_op, start_op;
    rsel_e rsel;
    logic  start, pause_req, resume_req;

    assign cmd    = decode_cmd(wr_data);
    assign rd_sel = rsel;

    srh_arbiter u_arb (
        .clk(clk), .rst(rst), .wr_en(wr_en), .cmd(cmd), .eng(eng), .cur_op(cur_op),
        .start(start), .start_op(start_op), .pause_req(pause_req),
        .resume_req(resume_req), .rsel(rsel)
    );

    srh_engine #(
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
        .FACT_CYC(FACT_CYC), .SETTLE_CYC(SETTLE_CYC)
    ) u_eng (
        .clk(clk), .rst(rst), .start(start), .start_op(start_op),
        .pause_req(pause_req), .resume_req(resume_req), .state(eng), .cur_op(cur_op)
    );

    srh_status #(.AW(AW), .BLK_LSB(BLK_LSB)) u_stat (
        .clk(clk), .rst(rst), .start(start), .wr_addr(wr_addr), .eng(eng),
        .cur_op(cur_op), .rsel(rsel), .rd_addr(rd_addr),
        .status(status), .rd_invalid(rd_invalid)
    );
endmodule

// File: rtl/srh_checker.sv
module srh_checker
    import srh_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] status,
    input logic [1:0] rd_sel,
    input logic       rd_invalid
);
    logic susp;
    cmd_e c;
    assign susp = status[6] | status[2];
    assign c    = decode_cmd(wr_data);

    a_r2_pause_after_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(susp) |-> $past(!status[7]));

    a_r3_status_shape: assert property (@(posedge clk) disable iff (rst)
        $onehot0({status[6], status[2]}) && (status[5:3] == 3'b0) &&
        (status[1:0] == 2'b0) && (!susp || status[7]));

    a_r4_resume_restarts: assert property (@(posedge clk) disable iff (rst)
        (wr_en && susp && c == C_RESUME) |=> (!status[7] && !status[6] && !status[2]));

    a_r5_stays_suspended: assert property (@(posedge clk) disable iff (rst)
        (wr_en && susp && c != C_RESUME) |=> $stable(status));

    a_r5_sel_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_en && susp && !is_read_sel(c)) |=> $stable(rd_sel));

    a_r6_invalid_needs_pause: assert property (@(posedge clk) disable iff (rst)
        rd_invalid |-> (susp && rd_sel == 2'd0));

    a_r7_idle_suspend: assert property (@(posedge clk) disable iff (rst)
        (wr_en && status[7] && !susp && c == C_SUSP) |=> $stable(status));
endmodule

bind srh_top srh_checker u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .status(status), .rd_sel(rd_sel), .rd_invalid(rd_invalid)
);

// File: tb/srh_top_tb.sv
`timescale 1ns/1ps
module srh_top_tb;
    localparam int AW = 12, BLK_LSB = 6, PROG_CYC = 6, ERASE_CYC = 24, FACT_CYC = 12, SETTLE_CYC = 3;

    logic clk = 0, rst = 1, wr_en = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0, status;
    logic [1:0] rd_sel;
    logic rd_invalid;
    int errors = 0, checks = 0;

    always #5 clk = ~clk;

    srh_top #(.AW(AW), .BLK_LSB(BLK_LSB), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
              .FACT_CYC(FACT_CYC), .SETTLE_CYC(SETTLE_CYC)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .status(status), .rd_sel(rd_sel), .rd_invalid(rd_invalid));

    // reference model: 0 idle, 1 run, 2 settle, 3 paused; op 0 prog, 1 erase, 2 factory
    int m_st = 0, m_cnt = 0, m_set = 0, m_op = 0, m_rs = 0;
    logic [AW-1:0] m_tgt = '0;

    function automatic logic [7:0] exp_status();
        logic [7:0] s = 8'h00;
        s[7] = (m_st == 0) || (m_st == 3);
        s[6] = (m_st == 3) && (m_op == 1);
        s[2] = (m_st == 3) && (m_op == 0);
        return s;
    endfunction

    function automatic logic exp_invalid(input logic [AW-1:0] ra);
        logic h;
        if (m_op == 1) h = (ra[AW-1:BLK_LSB] == m_tgt[AW-1:BLK_LSB]);
        else           h = (ra == m_tgt);
        return (m_st == 3) && (m_rs == 0) && h;
    endfunction

    task automatic model(input logic we, input logic [7:0] d, input logic [AW-1:0] a);
        int st = m_st;
        logic started = 0;
        case (st)
            0: if (we && (d == 8'h41 || d == 8'h22 || d == 8'h83)) begin
                   m_st = 1; started = 1; m_tgt = a;
                   m_op  = (d == 8'h41) ? 0 : (d == 8'h22) ? 1 : 2;
                   m_cnt = (m_op == 0) ? PROG_CYC : (m_op == 1) ? ERASE_CYC : FACT_CYC;
               end
            1: if (m_cnt == 1) begin m_st = 0; m_cnt = 0; end
               else begin
                   m_cnt--;
                   if (we && d == 8'hB5 && m_op != 2) begin m_st = 2; m_set = SETTLE_CYC; end
               end
            2: begin m_set--; if (m_set == 0) m_st = 3; end
            default: if (we && d == 8'hD5) m_st = 1;
        endcase
        if (we && d == 8'hFF) m_rs = 0;
        else if (we && d == 8'h70) m_rs = 1;
        else if (we && d == 8'h90) m_rs = 2;
        else if (started) m_rs = 1;
    endtask

    task automatic chk(input string tag, input logic ok, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [7:0] d, input logic [AW-1:0] a,
                        input logic [AW-1:0] ra, input string tag);
        @(negedge clk);
        wr_en = we; wr_data = d; wr_addr = a; rd_addr = ra;
        model(we, d, a);
        @(posedge clk); #1;
        wr_en = 0;
        chk(tag, status == exp_status() && rd_sel == 2'(m_rs) && rd_invalid == exp_invalid(ra),
            {status, 5'd0, rd_sel, rd_invalid}, {exp_status(), 5'd0, 2'(m_rs), exp_invalid(ra)});
    endtask

    task automatic idle_n(input int n, input logic [AW-1:0] ra, input string tag);
        for (int i = 0; i < n; i++) step(0, 8'h00, '0, ra, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] codes [10] = '{8'h41, 8'h22, 8'h83, 8'hB5, 8'hD5, 8'hFF, 8'h70, 8'h90, 8'h00, 8'h5A};
        int seed = 17;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1 chk("R3 reset", status == 8'h80 && rd_sel == 0 && !rd_invalid, {status, 8'(rd_sel)}, 16'h8000);

        // R7: suspend while idle
        step(1, 8'hB5, 12'h3C0, 12'h000, "R7");
        idle_n(2, 12'h000, "R7");

        // R1: program, run to completion
        step(1, 8'h41, 12'h123, 12'h123, "R1");
        chk("R1 busy", status == 8'h00 && rd_sel == 2'd1, {8'h0, status}, 16'h0000);
        idle_n(PROG_CYC - 1, 12'h123, "R1");
        chk("R1 still busy", status[7] == 1'b0, {15'h0, status[7]}, 16'h0000);
        idle_n(1, 12'h123, "R1");
        chk("R1 done", status == 8'h80, {8'h0, status}, 16'h0080);

        // R2, R4, R6, R10: program pause and resume
        step(1, 8'h41, 12'h245, 12'h245, "R1");
        idle_n(1, 12'h245, "R1");
        step(1, 8'hB5, 12'hF00, 12'h245, "R2");
        step(1, 8'hD5, 12'h000, 12'h245, "R10");
        step(1, 8'hB5, 12'h000, 12'h245, "R10");
        idle_n(1, 12'h245, "R2");
        chk("R2 program paused", status == 8'h84, {8'h0, status}, 16'h0084);
        step(1, 8'hFF, 12'h000, 12'h245, "R9");
        chk("R6 word hit", rd_invalid == 1'b1, {15'h0, rd_invalid}, 16'h0001);
        step(0, 8'h00, 12'h000, 12'h246, "R6");
        chk("R6 neighbour word", rd_invalid == 1'b0, {15'h0, rd_invalid}, 16'h0000);
        step(1, 8'hD5, 12'h000, 12'h245, "R4");
        chk("R4 resumed", status == 8'h00, {8'h0, status}, 16'h0000);
        idle_n(PROG_CYC, 12'h245, "R4");
        chk("R4 finished on count", status == 8'h80, {8'h0, status}, 16'h0080);

        // R5, R6, R9: erase pause with whitelist
        step(1, 8'h22, 12'h4C7, 12'h000, "R1");
        step(1, 8'h41, 12'h111, 12'h000, "R10");
        step(1, 8'hB5, 12'h010, 12'h000, "R2");
        idle_n(SETTLE_CYC, 12'h000, "R2");
        chk("R2 erase paused", status == 8'hC0, {8'h0, status}, 16'h00C0);
        foreach (codes[i]) if (!(codes[i] inside {8'hD5, 8'hFF, 8'h70, 8'h90}))
            step(1, codes[i], 12'h4C0, 12'h4C0, "R5");
        step(1, 8'hFF, 12'h000, 12'h4FF, "R6");
        chk("R6 block hit", rd_invalid == 1'b1, {15'h0, rd_invalid}, 16'h0001);
        step(0, 8'h00, 12'h000, 12'h500, "R6");
        chk("R6 other block", rd_invalid == 1'b0, {15'h0, rd_invalid}, 16'h0000);
        step(1, 8'h90, 12'h000, 12'h4C7, "R9");
        chk("R9 signature", rd_sel == 2'd2 && !rd_invalid, {14'h0, rd_sel}, 16'h0002);
        step(1, 8'h70, 12'h000, 12'h4C7, "R9");
        chk("R5 still paused", status == 8'hC0, {8'h0, status}, 16'h00C0);
        step(1, 8'hD5, 12'h000, 12'h4C7, "R4");
        idle_n(ERASE_CYC, 12'h4C7, "R4");

        // R8: factory ignores suspend
        step(1, 8'h83, 12'h700, 12'h700, "R1");
        step(1, 8'hB5, 12'h700, 12'h700, "R8");
        idle_n(SETTLE_CYC + 1, 12'h700, "R8");
        chk("R8 still running", status == 8'h00, {8'h0, status}, 16'h0000);
        idle_n(FACT_CYC, 12'h700, "R8");
        chk("R8 ended", status == 8'h80, {8'h0, status}, 16'h0080);

        // random traffic, all requirements checked through the model
        for (int n = 0; n < 4000; n++) begin
            logic we = ($urandom % 2) == 0;
            logic [7:0] d = codes[$urandom % 10];
            logic [AW-1:0] a = AW'($urandom);
            logic [AW-1:0] ra = ($urandom % 2) ? (m_tgt ^ AW'($urandom % 4)) : AW'($urandom);
            step(we, d, a, ra, "R3 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule